// File: doc/BRIEF.md
# Serial DAC Input and Update Register Front End

This block is the digital front end of a 16-bit serial-input converter. The host frames each write with an active-low select line. While the frame is open, the host clocks one data bit per falling edge of the serial clock, most significant bit first. The block collects the bits in a shift stage. When the select line rises after a complete word, the word is copied into an input register.

The word reaches the DAC register, whose value is the block's output, by one of two paths:
- **Synchronous update:** the load pin is held low, and the transfer happens as the frame closes.
- **Asynchronous update:** the load pin is high when the frame closes, and the transfer waits for the next falling edge of the load pin.

An active-low clear pin drives the DAC register to a fixed clear code. It does not disturb the input register.

All five pins are asynchronous to the block. Each passes through a two-flop synchronizer, and edges are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `serdac_frontend`

## Requirements
- R1: After reset, `dac_code_o` reads 0x0000.
- R2: A frame opens on a falling edge of `sel_n_i`. Data bits are taken from `sdi_i` on falling edges of `sck_i` while `sel_n_i` is low. The first bit received becomes bit 15 of the word, and the sixteenth becomes bit 0.
- R3: If `load_n_i` is low when `sel_n_i` rises after a complete 16-bit frame, the DAC register takes the new word.
- R4: If `load_n_i` is high when the frame closes, `dac_code_o` keeps its old value. On the next falling edge of `load_n_i`, it takes the new word.
- R5: A frame closed with fewer than 16 bits is discarded. Neither the input register nor the DAC register changes.
- R6: Bits clocked after the sixteenth bit of a frame are ignored. The first 16 bits are kept.
- R7: While `clear_n_i` is low, `dac_code_o` is 0x0000. After release it stays 0x0000 until the next update. The input register keeps its contents, and a later falling edge of `load_n_i` restores the held word.
- R8: A falling edge of `load_n_i` with no new frame since the previous transfer reloads the same input register word.
- R9: Falling edges of `sck_i` while `sel_n_i` is high capture nothing.
- R10: In synchronous mode, `dac_code_o` changes on the third rising system clock edge after `sel_n_i` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low frame select |
| sck_i | input | 1 | Serial clock; data captured on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Load control: its level picks the update mode, and its falling edge triggers an asynchronous load |
| clear_n_i | input | 1 | Active-low clear of the DAC register |
| dac_code_o | output | 16 | Current DAC register value |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a zero clear code and two synchronizer stages. With a serial clock eight system clocks long, these settings make every frame-length corner reachable in a short run: short frames, exact 16-bit frames and overlong frames. The same settings make the exact three-cycle pin-to-output latency observable. They also allow the clear, the reload and the asynchronous-mode sequences to be mixed freely.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  // pin positions inside the synchronized vector
  localparam int unsigned PIN_SEL   = 0;
  localparam int unsigned PIN_SCK   = 1;
  localparam int unsigned PIN_SDI   = 2;
  localparam int unsigned PIN_LOAD  = 3;
  localparam int unsigned PIN_CLEAR = 4;
  localparam int unsigned N_PINS    = 5;
  // idle levels: select, clock, load and clear high; data low
  localparam logic [N_PINS-1:0] PIN_IDLE = 5'b11011;

  function automatic logic frame_complete(input int unsigned got, input int unsigned want);
    return got == want;
  endfunction

  function automatic logic room_left(input int unsigned got, input int unsigned want);
    return got < want;
  endfunction
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {(STAGES+1){RST_VAL}};
    else        stg_q <= {stg_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o =  stg_q[STAGES-1] & ~stg_q[STAGES];
  assign fall_o = ~stg_q[STAGES-1] &  stg_q[STAGES];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter
  import serdac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_fall,
  input  logic              sdi_lvl,
  output logic              frame_ok,
  output logic [DATA_W-1:0] word_o,
  output logic [CW-1:0]     bit_cnt
);
  logic              open_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] shf_q;

  function automatic logic [DATA_W-1:0] push_bit(input logic [DATA_W-1:0] w, input logic b);
    return {w[DATA_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      shf_q  <= '0;
    end else if (sel_fall) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sel_rise) begin
      open_q <= 1'b0;
    end else if (open_q && sck_fall && room_left(32'(cnt_q), DATA_W)) begin
      shf_q <= push_bit(shf_q, sdi_lvl);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_ok = sel_rise && open_q && frame_complete(32'(cnt_q), DATA_W);
  assign word_o   = shf_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/serdac_regs.sv
module serdac_regs #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] CLEAR_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_lvl,
  input  logic              load_fall,
  input  logic              clear_lvl,
  output logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] dac_code
);
  logic [DATA_W-1:0] in_q, dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_q <= '0;
    else if (frame_ok) in_q <= word_i;
  end

  // clear dominates; a frame closing with load low beats a coincident load edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dac_q <= CLEAR_CODE;
    else if (!clear_lvl)            dac_q <= CLEAR_CODE;
    else if (frame_ok && !load_lvl) dac_q <= word_i;
    else if (load_fall)             dac_q <= in_q;
  end

  assign in_word  = in_q;
  assign dac_code = dac_q;
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
  import serdac_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CLEAR_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              load_n_i,
  input  logic              clear_n_i,
  output logic [DATA_W-1:0] dac_code_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);

  logic [N_PINS-1:0] pins, lvl, rise, fall;
  logic sel_rise, sel_fall, sck_fall, sdi_lvl, load_lvl, load_fall, clear_lvl;
  logic              frame_ok;
  logic [DATA_W-1:0] shift_word, in_word, dac_code;
  logic [CW-1:0]     bit_cnt;

  assign pins[PIN_SEL]   = sel_n_i;
  assign pins[PIN_SCK]   = sck_i;
  assign pins[PIN_SDI]   = sdi_i;
  assign pins[PIN_LOAD]  = load_n_i;
  assign pins[PIN_CLEAR] = clear_n_i;

  serdac_sync #(.W(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign sel_rise  = rise[PIN_SEL];
  assign sel_fall  = fall[PIN_SEL];
  assign sck_fall  = fall[PIN_SCK];
  assign sdi_lvl   = lvl[PIN_SDI];
  assign load_lvl  = lvl[PIN_LOAD];
  assign load_fall = fall[PIN_LOAD];
  assign clear_lvl = lvl[PIN_CLEAR];

  serdac_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_fall(sck_fall), .sdi_lvl(sdi_lvl), .frame_ok(frame_ok),
    .word_o(shift_word), .bit_cnt(bit_cnt)
  );

  serdac_regs #(.DATA_W(DATA_W), .CLEAR_CODE(CLEAR_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .word_i(shift_word),
    .load_lvl(load_lvl), .load_fall(load_fall), .clear_lvl(clear_lvl),
    .in_word(in_word), .dac_code(dac_code)
  );

  assign dac_code_o = dac_code;
endmodule

// File: rtl/serdac_frontend_chk.sv
module serdac_frontend_chk #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] CLEAR_CODE = '0,
  localparam int unsigned CW = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_rise,
  input logic              frame_ok,
  input logic              load_lvl,
  input logic              load_fall,
  input logic              clear_lvl,
  input logic [CW-1:0]     bit_cnt,
  input logic [DATA_W-1:0] shift_word,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] dac_code
);
  // R7
  clear_forces_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_lvl |=> dac_code == CLEAR_CODE);

  // R3
  sync_mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && !load_lvl && clear_lvl |=> dac_code == $past(shift_word));

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_lvl && !frame_ok && !load_fall |=> $stable(dac_code));

  // R8
  load_edge_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall && clear_lvl && !frame_ok |=> dac_code == $past(in_word));

  // R5
  short_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise && !frame_ok |=> $stable(in_word));

  // R6
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(DATA_W));
endmodule

bind serdac_frontend serdac_frontend_chk #(.DATA_W(DATA_W), .CLEAR_CODE(CLEAR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_rise(sel_rise), .frame_ok(frame_ok),
  .load_lvl(load_lvl), .load_fall(load_fall), .clear_lvl(clear_lvl),
  .bit_cnt(bit_cnt), .shift_word(shift_word), .in_word(in_word), .dac_code(dac_code)
);

// File: tb/serdac_frontend_tb.sv
`timescale 1ns/1ps
module serdac_frontend_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b1, sdi = 1'b0, load_n = 1'b0, clear_n = 1'b1;
  logic [15:0] dac;

  always #4 clk = ~clk;   // 125 MHz

  serdac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
    .load_n_i(load_n), .clear_n_i(clear_n), .dac_code_o(dac)
  );

  typedef struct { logic [15:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  event mon_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_in = 16'h0000, m_dac = 16'h0000;   // bench model

  // monitor: pops expectations and compares with the port
  initial forever begin
    @(mon_ev);
    while (exp_q.size() != 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (dac !== it.val) begin
        n_fail++;
        $display("FAIL %s: dac_code_o=%h expected %h", it.tag, dac, it.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_dac(input logic [15:0] v, input string tag);
    exp_t it;
    it.val = v; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
  endtask

  // one serial bit: falling sck edge mid-bit, data stable around it
  task automatic send_bit(input logic b);
    sdi = b; tick(2);
    sck = 1'b0; tick(4);
    sck = 1'b1; tick(2);
  endtask

  // frame of n bits, bits taken MSB first from data (extras beyond 16 are 1)
  task automatic send_frame(input logic [15:0] data, input int n, input bit wait_after);
    sel_n = 1'b0; tick(4);
    for (int i = 0; i < n; i++) send_bit(i < 16 ? data[15-i] : 1'b1);
    tick(4);
    sel_n = 1'b1;
    if (n >= 16) begin
      m_in = data;
      if (!load_n && clear_n) m_dac = m_in;
    end
    if (wait_after) tick(8);
  endtask

  task automatic load_pulse();
    load_n = 1'b1; tick(6);
    load_n = 1'b0; tick(6);
    if (clear_n) m_dac = m_in;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    expect_dac(16'h0000, "R1 reset value");

    // synchronous mode, several patterns, bit order
    send_frame(16'hA5C3, 16, 1);
    expect_dac(m_dac, "R3 sync load 0xA5C3");
    send_frame(16'h0001, 16, 1);
    expect_dac(16'h0001, "R2 last bit lands in bit0");
    send_frame(16'h8000, 16, 1);
    expect_dac(16'h8000, "R2 first bit lands in bit15");

    // latency: change on third edge after select rises
    send_frame(16'h3C3C, 16, 0);
    tick(2);
    expect_dac(16'h8000, "R10 no change before third edge");
    tick(1);
    expect_dac(16'h3C3C, "R10 change at third edge");
    tick(6);

    // asynchronous mode
    load_n = 1'b1; tick(6);
    send_frame(16'h1234, 16, 1);
    expect_dac(16'h3C3C, "R4 held while load high");
    load_n = 1'b0; tick(6);
    m_dac = m_in;
    expect_dac(16'h1234, "R4 load falling edge transfers");

    // short frame discarded in async mode, then reload proves input reg intact
    load_n = 1'b1; tick(6);
    send_frame(16'hFFFF, 10, 1);
    expect_dac(16'h1234, "R5 short frame leaves dac");
    load_n = 1'b0; tick(6);
    expect_dac(16'h1234, "R5 short frame leaves input register");
    load_pulse();
    expect_dac(m_dac, "R8 reload same word");

    // short frame in sync mode
    send_frame(16'h0F0F, 15, 1);
    expect_dac(16'h1234, "R5 fifteen bits discarded");

    // overlong frame
    send_frame(16'h5A5A, 18, 1);
    expect_dac(16'h5A5A, "R6 extra bits ignored");

    // clear
    clear_n = 1'b0; tick(6);
    m_dac = 16'h0000;
    expect_dac(16'h0000, "R7 clear forces zero");
    clear_n = 1'b1; tick(6);
    expect_dac(16'h0000, "R7 zero held after release");
    load_pulse();
    expect_dac(16'h5A5A, "R7 input register kept across clear");

    // serial clock toggling while not selected
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin sck = 1'b0; tick(4); sck = 1'b1; tick(4); end
    sdi = 1'b0;
    load_pulse();
    expect_dac(16'h5A5A, "R9 idle clocks captured nothing");

    tick(4);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule